// File: doc/BRIEF.md
# Security-Banked System Handler Status Register

This block is one 32-bit control and status word for the system exception handlers of a core that runs in a Secure and a Non-secure state. For most handlers it keeps two copies of the active, pending and enable flags, one per security state. The security attribute of each access picks which copy is read or written. Some flags exist only once. Of these, a few are visible to secure accesses only, and a few are visible when the access is secure or when a global "bus/hard/NMI faults go to non-secure" setting is on.

Two active flags can only be cleared through software under a narrow condition: the NMI flag and the non-secure hard-fault flag. Exception entry logic outside the block sets these two flags, and the secure hard-fault flag, through dedicated pulse inputs. Every write that hits the register raises a one-cycle strobe so that the prioritisation logic can recompute the pending exception.

The access port is a plain register port and has no handshake. A read returns data in the same cycle. A write takes effect on the clock edge.

Top module: `handler_status_reg`

## Requirements
- R1: All flags reset to zero. The register decodes at byte address 0xD24. Read data is zero at any other address, and writes to any other address change nothing.
- R2: Ten fields have one copy per security state, and the access attribute selects the copy: memory-fault active (bit 0), usage-fault active (3), service-call active (7), pendable-service active (10), tick active (11), usage-fault pending (12), memory-fault pending (13), service-call pending (15), memory-fault enable (16) and usage-fault enable (18). A write to one copy leaves the other copy unchanged.
- R3: Hard-fault active (bit 2) and hard-fault pending (bit 21) are also kept per state. Writes can never change the secure hard-fault active flag; only its set input can raise it.
- R4: The security-fault flags have a single copy: active (bit 4), enable (bit 19) and pending (bit 20). Secure accesses read and write them. Non-secure accesses read zeros there, and non-secure writes leave them unchanged.
- R5: The bus-fault flags have a single copy: active (bit 1), pending (bit 14) and enable (bit 17). They can be read and written when the access is secure or the faults-to-non-secure input is high. Otherwise they read zero and writes leave them unchanged. A secure write to bit 17 updates the bus-fault enable.
- R6: Bit 5 shows the NMI active flag under the same visibility rule as R5. Only its set input raises that flag.
- R7: A write clears the NMI active flag only when four conditions all hold: the access is non-secure, the core is in secure state, faults-to-non-secure is high, and written bit 5 is 0. Writing 1 has no effect.
- R8: The non-secure hard-fault active flag is cleared only under the same four-part condition, applied to written bit 2.
- R9: Debug-monitor active (bit 8) has a single copy that both states read and write.
- R10: While legacy mode is high, bits 2, 5 and 21 read zero, and writes to them have no effect.
- R11: A write that hits the register raises the update strobe for exactly the next cycle. There is no strobe in any other cycle.
- R12: Bits 6, 9 and 22 to 31 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_mode_i | input | 1 | Profile without security extension |
| core_secure_i | input | 1 | Core currently in secure state |
| faults_to_ns_i | input | 1 | Bus/hard/NMI faults target non-secure |
| wr_en_i | input | 1 | Write enable |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | 32 | Write data |
| acc_secure_i | input | 1 | Security attribute of the access |
| hw_set_nmi_act_i | input | 1 | Pulse from exception entry: set NMI active |
| hw_set_hf_act_i | input | 2 | Pulse: set hard-fault active (bit 1 secure, bit 0 non-secure) |
| rdata_o | output | 32 | Read data (combinational) |
| ns_flags_o | output | 12 | Non-secure banked handler flags |
| s_flags_o | output | 12 | Secure banked handler flags |
| shared_flags_o | output | 8 | Single-copy handler flags |
| upd_strobe_o | output | 1 | One-cycle re-evaluation strobe |

## Verification
Read data is combinational, so a wrong flag in either bank shows up in the very next read with the matching attribute. A wrong flag in a single-copy flag shows up in the next read whose attribute and faults-to-non-secure setting make that field visible. Fault in the visibility logic, such as a leak of secure-only fields or a missing legacy mask, shows up in the same cycle as the read. A corrupted clear condition stays hidden until a later read of bit 2 or bit 5 under a visible combination. For that reason the bench reads both banks after every clear attempt. A missing or extra strobe appears exactly one cycle after the write edge.

// File: rtl/shs_pkg.sv
package shs_pkg;
  localparam int unsigned DATA_W = 32;

  localparam int unsigned P_MEM_ACT  = 0;
  localparam int unsigned P_BF_ACT   = 1;
  localparam int unsigned P_HF_ACT   = 2;
  localparam int unsigned P_USG_ACT  = 3;
  localparam int unsigned P_SF_ACT   = 4;
  localparam int unsigned P_NMI_ACT  = 5;
  localparam int unsigned P_SVC_ACT  = 7;
  localparam int unsigned P_DBG_ACT  = 8;
  localparam int unsigned P_PSV_ACT  = 10;
  localparam int unsigned P_TICK_ACT = 11;
  localparam int unsigned P_USG_PEND = 12;
  localparam int unsigned P_MEM_PEND = 13;
  localparam int unsigned P_BF_PEND  = 14;
  localparam int unsigned P_SVC_PEND = 15;
  localparam int unsigned P_MEM_EN   = 16;
  localparam int unsigned P_BF_EN    = 17;
  localparam int unsigned P_USG_EN   = 18;
  localparam int unsigned P_SF_EN    = 19;
  localparam int unsigned P_SF_PEND  = 20;
  localparam int unsigned P_HF_PEND  = 21;

  localparam logic [DATA_W-1:0] RSVD_MASK   = 32'hFFC0_0240;
  localparam logic [DATA_W-1:0] SF_MASK     = 32'h0018_0010;
  localparam logic [DATA_W-1:0] BUS_MASK    = 32'h0002_4002;
  localparam logic [DATA_W-1:0] LEGACY_MASK = 32'h0020_0024;

  typedef struct packed {
    logic hf_pend;
    logic hf_act;
    logic usg_en;
    logic mem_en;
    logic svc_pend;
    logic mem_pend;
    logic usg_pend;
    logic tick_act;
    logic psv_act;
    logic svc_act;
    logic usg_act;
    logic mem_act;
  } bank_t;

  typedef struct packed {
    logic dbg_act;
    logic nmi_act;
    logic bf_en;
    logic bf_pend;
    logic bf_act;
    logic sf_pend;
    logic sf_en;
    logic sf_act;
  } shared_t;

  localparam int unsigned BANK_W   = $bits(bank_t);
  localparam int unsigned SHARED_W = $bits(shared_t);
endpackage

// File: rtl/shs_bank.sv
module shs_bank
  import shs_pkg::*;
#(
  parameter bit IS_SECURE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              hf_pend_ok_i,
  input  logic              hf_clr_ok_i,
  input  logic              hw_set_hf_i,
  output bank_t             q_o
);
  bank_t q;
  logic  unused_bits;
  assign unused_bits = ^{wdata_i[31:22], wdata_i[20:19], wdata_i[17], wdata_i[14],
                         wdata_i[9:8], wdata_i[6:4], wdata_i[1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      if (wr_i) begin
        q.mem_act  <= wdata_i[P_MEM_ACT];
        q.usg_act  <= wdata_i[P_USG_ACT];
        q.svc_act  <= wdata_i[P_SVC_ACT];
        q.psv_act  <= wdata_i[P_PSV_ACT];
        q.tick_act <= wdata_i[P_TICK_ACT];
        q.usg_pend <= wdata_i[P_USG_PEND];
        q.mem_pend <= wdata_i[P_MEM_PEND];
        q.svc_pend <= wdata_i[P_SVC_PEND];
        q.mem_en   <= wdata_i[P_MEM_EN];
        q.usg_en   <= wdata_i[P_USG_EN];
        if (hf_pend_ok_i) q.hf_pend <= wdata_i[P_HF_PEND];
      end
      if (hf_clr_ok_i && !wdata_i[P_HF_ACT]) q.hf_act <= 1'b0;
      if (hw_set_hf_i) q.hf_act <= 1'b1;
    end
  end

  assign q_o = q;

  // R2: the bank moves only when its own write, clear or set is present
  assert_bank_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && !hf_clr_ok_i && !hw_set_hf_i) |=> $stable(q));

  // R8: hard-fault active never falls without the clear condition
  assert_hf_clear_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hf_clr_ok_i |=> !$fell(q.hf_act));

  generate
    if (IS_SECURE) begin : g_sec
      // R3: secure hard-fault active is only raised by its set input, never written
      assert_sec_hf_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_set_hf_i |=> $stable(q.hf_act));
    end
  endgenerate
endmodule

// File: rtl/shs_shared.sv
module shs_shared
  import shs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              sec_i,
  input  logic              bus_ok_i,
  input  logic              nmi_clr_ok_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              hw_set_nmi_i,
  output shared_t           q_o
);
  shared_t q;
  logic    unused_bits;
  assign unused_bits = ^{wdata_i[31:21], wdata_i[18], wdata_i[16:15], wdata_i[13:9],
                         wdata_i[7:6], wdata_i[3:2], wdata_i[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      if (wr_i && sec_i) begin
        q.sf_act  <= wdata_i[P_SF_ACT];
        q.sf_en   <= wdata_i[P_SF_EN];
        q.sf_pend <= wdata_i[P_SF_PEND];
      end
      if (wr_i && bus_ok_i) begin
        q.bf_act  <= wdata_i[P_BF_ACT];
        q.bf_pend <= wdata_i[P_BF_PEND];
        q.bf_en   <= wdata_i[P_BF_EN];
      end
      if (wr_i) q.dbg_act <= wdata_i[P_DBG_ACT];
      if (nmi_clr_ok_i && !wdata_i[P_NMI_ACT]) q.nmi_act <= 1'b0;
      if (hw_set_nmi_i) q.nmi_act <= 1'b1;
    end
  end

  assign q_o = q;

  // R4: security-fault flags move only on a secure write
  assert_sf_secure_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && sec_i) |=> $stable({q.sf_act, q.sf_en, q.sf_pend}));

  // R5: bus-fault flags move only on a permitted write
  assert_bus_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && bus_ok_i) |=> $stable({q.bf_act, q.bf_pend, q.bf_en}));

  // R6: NMI active rises only from its set input
  assert_nmi_set_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_set_nmi_i |=> !$rose(q.nmi_act));

  // R7: NMI active never falls without the four-part condition
  assert_nmi_clear_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_clr_ok_i |=> !$fell(q.nmi_act));
endmodule

// File: rtl/shs_rdmux.sv
module shs_rdmux
  import shs_pkg::*;
(
  input  logic              hit_i,
  input  logic              sec_i,
  input  logic              bus_ok_i,
  input  logic              legacy_i,
  input  bank_t             ns_q_i,
  input  bank_t             s_q_i,
  input  shared_t           sh_q_i,
  output logic [DATA_W-1:0] rdata_o
);
  bank_t bk;
  logic [DATA_W-1:0] r;

  always_comb begin
    bk = sec_i ? s_q_i : ns_q_i;
    r  = '0;
    r[P_MEM_ACT]  = bk.mem_act;
    r[P_USG_ACT]  = bk.usg_act;
    r[P_SVC_ACT]  = bk.svc_act;
    r[P_PSV_ACT]  = bk.psv_act;
    r[P_TICK_ACT] = bk.tick_act;
    r[P_USG_PEND] = bk.usg_pend;
    r[P_MEM_PEND] = bk.mem_pend;
    r[P_SVC_PEND] = bk.svc_pend;
    r[P_MEM_EN]   = bk.mem_en;
    r[P_USG_EN]   = bk.usg_en;
    r[P_HF_ACT]   = bk.hf_act  & ~legacy_i;
    r[P_HF_PEND]  = bk.hf_pend & ~legacy_i;
    r[P_DBG_ACT]  = sh_q_i.dbg_act;
    if (sec_i) begin
      r[P_SF_ACT]  = sh_q_i.sf_act;
      r[P_SF_EN]   = sh_q_i.sf_en;
      r[P_SF_PEND] = sh_q_i.sf_pend;
    end
    if (bus_ok_i) begin
      r[P_BF_ACT]  = sh_q_i.bf_act;
      r[P_BF_PEND] = sh_q_i.bf_pend;
      r[P_BF_EN]   = sh_q_i.bf_en;
      r[P_NMI_ACT] = sh_q_i.nmi_act & ~legacy_i;
    end
    if (!hit_i) r = '0;
  end

  assign rdata_o = r;
endmodule

// File: rtl/handler_status_reg.sv
module handler_status_reg
  import shs_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 12,
  parameter logic [ADDR_W-1:0]    REG_ADDR = 12'hD24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                legacy_mode_i,
  input  logic                core_secure_i,
  input  logic                faults_to_ns_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                acc_secure_i,
  input  logic                hw_set_nmi_act_i,
  input  logic [1:0]          hw_set_hf_act_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [BANK_W-1:0]   ns_flags_o,
  output logic [BANK_W-1:0]   s_flags_o,
  output logic [SHARED_W-1:0] shared_flags_o,
  output logic                upd_strobe_o
);
  localparam int unsigned NUM_BANKS = 2;

  logic    hit, wr_hit, bus_ok, clr_ok, upd_q;
  bank_t   banks [NUM_BANKS];
  shared_t sh_q;

  assign hit    = (addr_i == REG_ADDR);
  assign wr_hit = wr_en_i && hit;
  assign bus_ok = acc_secure_i || faults_to_ns_i;
  assign clr_ok = wr_hit && !acc_secure_i && core_secure_i && faults_to_ns_i && !legacy_mode_i;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam bit SEC = (b == 1);
      shs_bank #(.IS_SECURE(SEC)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (wr_hit && (acc_secure_i == SEC)),
        .wdata_i      (wdata_i),
        .hf_pend_ok_i (!legacy_mode_i),
        .hf_clr_ok_i  (SEC ? 1'b0 : clr_ok),
        .hw_set_hf_i  (hw_set_hf_act_i[b]),
        .q_o          (banks[b])
      );
    end
  endgenerate

  shs_shared u_shared (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_i         (wr_hit),
    .sec_i        (acc_secure_i),
    .bus_ok_i     (bus_ok),
    .nmi_clr_ok_i (clr_ok),
    .wdata_i      (wdata_i),
    .hw_set_nmi_i (hw_set_nmi_act_i),
    .q_o          (sh_q)
  );

  shs_rdmux u_rdmux (
    .hit_i    (hit),
    .sec_i    (acc_secure_i),
    .bus_ok_i (bus_ok),
    .legacy_i (legacy_mode_i),
    .ns_q_i   (banks[0]),
    .s_q_i    (banks[1]),
    .sh_q_i   (sh_q),
    .rdata_o  (rdata_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= wr_hit;
  end

  assign upd_strobe_o   = upd_q;
  assign ns_flags_o     = banks[0];
  assign s_flags_o      = banks[1];
  assign shared_flags_o = sh_q;

  // R11: strobe follows each hitting write by exactly one cycle
  assert_strobe_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> upd_strobe_o);
  assert_no_spurious_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> !upd_strobe_o);

  // R12: reserved positions read zero
  assert_reserved_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_o & RSVD_MASK) == '0);

  // R4: non-secure reads never expose security-fault flags
  assert_sf_hidden_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_secure_i |-> (rdata_o & SF_MASK) == '0);

  // R5: bus-fault flags hidden when the access may not see them
  assert_bus_hidden_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ok |-> (rdata_o & BUS_MASK) == '0);

  // R10: legacy profile masks the hard-fault and NMI positions
  assert_legacy_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_mode_i |-> (rdata_o & LEGACY_MASK) == '0);
endmodule

// File: tb/sim_handler_status_reg.sv
module sim_handler_status_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        legacy = 1'b0, csec = 1'b0, f2ns = 1'b0, wr_en = 1'b0, asec = 1'b0;
  logic [11:0] addr = 12'hD24;
  logic [31:0] wdata = '0;
  logic        set_nmi = 1'b0;
  logic [1:0]  set_hf = 2'b00;
  logic [31:0] rdata;
  logic [11:0] nsf, sf;
  logic [7:0]  shf;
  logic        strobe;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] v;

  localparam logic [11:0] A_REG = 12'hD24;
  localparam logic [11:0] A_OTH = 12'hD28;

  always #10 clk = ~clk;

  handler_status_reg u0 (
    .clk(clk), .rst_n(rst_n), .legacy_mode_i(legacy), .core_secure_i(csec),
    .faults_to_ns_i(f2ns), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .acc_secure_i(asec), .hw_set_nmi_act_i(set_nmi), .hw_set_hf_act_i(set_hf),
    .rdata_o(rdata), .ns_flags_o(nsf), .s_flags_o(sf), .shared_flags_o(shf),
    .upd_strobe_o(strobe)
  );

  typedef struct packed {
    logic        wen;
    logic        wsec;
    logic        wf2ns;
    logic [31:0] wd;
    logic        rsec;
    logic        rf2ns;
    logic [31:0] exp;
  } vec_t;

  // rows cover R2, R4, R5, R9
  localparam vec_t TBL [9] = '{
    '{1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0025_BD89},
    '{1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_0100},
    '{1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'h003F_FD9B},
    '{1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 32'h0025_BD89},
    '{1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b1, 32'h0027_FD8B},
    '{1'b1, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 32'h003F_FC9B},
    '{1'b1, 1'b0, 1'b1, 32'h0000_0000, 1'b1, 1'b0, 32'h003D_BC99},
    '{1'b1, 1'b1, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_0000},
    '{1'b1, 1'b1, 1'b0, 32'h0000_0100, 1'b0, 1'b0, 32'h0000_0100}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sec, input logic f, input logic cs,
                        input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    asec = sec; f2ns = f; csec = cs; addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = A_REG;
  endtask

  task automatic rd_reg(input logic sec, input logic f, output logic [31:0] r);
    asec = sec; f2ns = f; addr = A_REG;
    #1;
    r = rdata;
  endtask

  task automatic pulse_set(input logic nmi, input logic [1:0] hf);
    @(negedge clk);
    set_nmi = nmi; set_hf = hf;
    @(negedge clk);
    set_nmi = 1'b0; set_hf = 2'b00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state of both banks and strobe
    rd_reg(1'b1, 1'b1, v); chk("R1 reset secure read", v, 32'h0);
    rd_reg(1'b0, 1'b1, v); chk("R1 reset non-secure read", v, 32'h0);
    chk("R11 no strobe after reset", {31'b0, strobe}, 32'h0);

    // R1: other address: no effect, no strobe, reads zero
    wr_reg(1'b1, 1'b0, 1'b0, A_OTH, 32'hFFFF_FFFF);
    chk("R11 no strobe for miss", {31'b0, strobe}, 32'h0);
    rd_reg(1'b1, 1'b1, v); chk("R1 miss write ignored", v, 32'h0);
    asec = 1'b1; addr = A_OTH; #1;
    chk("R1 miss read zero", rdata, 32'h0);
    addr = A_REG;

    // table walk
    foreach (TBL[i]) begin
      if (TBL[i].wen) wr_reg(TBL[i].wsec, TBL[i].wf2ns, 1'b0, A_REG, TBL[i].wd);
      else @(negedge clk);
      rd_reg(TBL[i].rsec, TBL[i].rf2ns, v);
      chk($sformatf("R2 R4 R5 R9 table row %0d", i), v, TBL[i].exp);
    end

    // R11: strobe one cycle, then low
    wr_reg(1'b1, 1'b0, 1'b0, A_REG, 32'hFFFF_FFFF);
    chk("R11 strobe after write", {31'b0, strobe}, 32'h1);
    rd_reg(1'b1, 1'b0, v);
    chk("R12 reserved zero", v & 32'hFFC0_0240, 32'h0);
    @(negedge clk);
    chk("R11 strobe drops", {31'b0, strobe}, 32'h0);
    wr_reg(1'b1, 1'b0, 1'b0, A_REG, 32'h0);

    // R6 R3 R8: hardware sets
    pulse_set(1'b1, 2'b11);
    rd_reg(1'b1, 1'b0, v); chk("R6 secure sees nmi and hf", v & 32'h24, 32'h24);
    rd_reg(1'b0, 1'b0, v); chk("R6 nmi hidden ns", v & 32'h24, 32'h04);
    rd_reg(1'b0, 1'b1, v); chk("R6 nmi visible with f2ns", v & 32'h24, 32'h24);

    // R3: secure write of zero keeps secure hard-fault active; R7 nmi kept
    wr_reg(1'b1, 1'b1, 1'b1, A_REG, 32'h0);
    rd_reg(1'b1, 1'b0, v); chk("R3 secure hf act not writable", v & 32'h24, 32'h24);

    // R7 R8: partial conditions do not clear
    wr_reg(1'b0, 1'b1, 1'b0, A_REG, 32'h0);
    rd_reg(1'b0, 1'b1, v); chk("R8 no clear core non-secure", v & 32'h24, 32'h24);
    wr_reg(1'b0, 1'b0, 1'b1, A_REG, 32'h0);
    rd_reg(1'b0, 1'b1, v); chk("R7 no clear without f2ns", v & 32'h24, 32'h24);
    wr_reg(1'b0, 1'b1, 1'b1, A_REG, 32'h24);
    rd_reg(1'b0, 1'b1, v); chk("R7 writing one no effect", v & 32'h24, 32'h24);

    // R8: clear ns hard-fault only
    wr_reg(1'b0, 1'b1, 1'b1, A_REG, 32'h20);
    rd_reg(1'b0, 1'b1, v); chk("R8 ns hf cleared", v & 32'h24, 32'h20);
    rd_reg(1'b1, 1'b0, v); chk("R3 secure hf unaffected", v & 32'h04, 32'h04);

    // R7: clear nmi
    wr_reg(1'b0, 1'b1, 1'b1, A_REG, 32'h04);
    rd_reg(1'b1, 1'b0, v); chk("R7 nmi cleared", v & 32'h24, 32'h04);

    // R10: legacy masks and ignores
    legacy = 1'b1;
    rd_reg(1'b1, 1'b0, v); chk("R10 legacy masks secure hf", v & 32'h24, 32'h0);
    wr_reg(1'b0, 1'b0, 1'b0, A_REG, 32'h0020_0000);
    rd_reg(1'b0, 1'b0, v); chk("R10 legacy pend reads zero", v & 32'h0020_0000, 32'h0);
    legacy = 1'b0;
    rd_reg(1'b0, 1'b0, v); chk("R10 legacy write ignored", v & 32'h0020_0000, 32'h0);
    rd_reg(1'b1, 1'b0, v); chk("R10 secure hf back after legacy", v & 32'h04, 32'h04);

    // R3: non-legacy ns hard-fault pending is writable
    wr_reg(1'b0, 1'b0, 1'b0, A_REG, 32'h0020_0000);
    rd_reg(1'b0, 1'b0, v); chk("R3 ns hf pend written", v & 32'h0020_0000, 32'h0020_0000);
    rd_reg(1'b1, 1'b0, v); chk("R3 secure hf pend separate", v & 32'h0020_0000, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule